// File: doc/BRIEF.md
# Per-Pin Edge-Select Interrupt Controller

This block combines event sources from a bank of general-purpose input pins onto one active-low interrupt line. The pin levels arrive already synchronised, along with a direction vector that says which pins are inputs. A byte-wide register port lets a host set each pin's trigger condition, mask it, and choose whether its event is held. The same port reads back which pins are pending and acknowledges them with a write-one-to-clear operation.

Each pin has one of four trigger codes. Three of them act on an edge of the pin's input. The fourth compares the pin with a reference level, and the pin's byte refreshes that reference every time the host reads its live levels. An unlatched pin drops its event as soon as the input leaves the level it had when the event fired. A latched pin keeps the event until the host clears it. With the default parameters the block serves 24 pins, arranged as three bytes.

Top module: `pin_irq_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset, every pin is masked, so address 0x04+k reads 0xFF. Nothing is pending, and `irq_n` is 1.
- R2: A pin whose `pin_is_input` bit is 0 never becomes pending. Its status bit stays 0 and it does not pull `irq_n` low.
- R3: A pin whose mask bit is 1 (register 0x04+k, bit i, for pin 8k+i) never becomes pending. Its status bit reads 0.
- R4: Trigger code 01 fires only on a 0-to-1 transition of the pin. A 1-to-0 transition does nothing.
- R5: Trigger code 10 fires only on a 1-to-0 transition of the pin. A 0-to-1 transition does nothing.
- R6: Trigger code 11 fires on both transitions.
- R7: Trigger code 00 fires while the pin differs from its reference bit. A read of address 0x18+k copies pins 8k..8k+7 into the reference and returns their current levels. After reset the reference is 0.
- R8: When a pin's latch bit is 0 (register 0x00+k, bit i) and its event is pending, the event drops in the cycle after the pin leaves the level it had when the event fired, unless a new event fires in that same cycle.
- R9: When a pin's latch bit is 1, its pending event survives any later change of the pin level and is removed only by a clear.
- R10: Writing 1 to bit i of address 0x10+k clears the pending event of pin 8k+i, and writing 0 leaves it unchanged. The clear register reads 0. If a clear and a new event for the same pin arrive in the same cycle, the pin stays pending.
- R11: Address 0x14+k bit i reads 1 when pin 8k+i is pending, unmasked and an input. `irq_n` is 0 exactly when some status bit is 1. It follows an input change on the clock edge after that change.
- R12: The trigger code of pin 4j+i sits in bits [2i+1:2i] of address 0x08+j. The latch, mask and trigger registers read back what was last written. `rdata` is loaded on the clock edge at which `rd_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| pin_level | input | NPINS | Synchronised pin levels |
| pin_is_input | input | NPINS | 1 where the pin is configured as an input |
| rdata | output | 8 | Read data, registered |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Directed cases run a single pin through each trigger code with a rise-then-fall pattern. This pattern tells a rising trigger apart from a falling one and from a both-edge one, and it shows whether a revert drops the event (unlatched) or keeps it (latched). Further cases cover a reference refresh that moves the change trigger's comparison point, a clear that lands together with a new edge, and a masked pin and an output pin toggled under both-edge triggering. A pin in the middle byte confirms the status bit positions. Seeded random toggles, configuration writes, clears and reads then exercise mixed configurations against a bench model.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    // Trigger selection per pin (2 bits)
    typedef enum logic [1:0] {
        TRIG_CHANGE = 2'b00,
        TRIG_RISE   = 2'b01,
        TRIG_FALL   = 2'b10,
        TRIG_BOTH   = 2'b11
    } trig_mode_e;

    // Register map bases; byte k of a group lives at base + k
    localparam logic [7:0] A_LATCH = 8'h00;
    localparam logic [7:0] A_MASK  = 8'h04;
    localparam logic [7:0] A_EDGE  = 8'h08;
    localparam logic [7:0] A_CLEAR = 8'h10;
    localparam logic [7:0] A_STAT  = 8'h14;
    localparam logic [7:0] A_LEVEL = 8'h18;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] addr;
        logic [7:0] data;
    } bus_req_t;

    typedef struct packed {
        logic cur;
        logic prev;
        logic ref_lvl;
    } pin_view_t;

    function automatic logic fires(trig_mode_e m, pin_view_t v);
        logic f;
        case (m)
            TRIG_CHANGE: f = v.cur ^ v.ref_lvl;
            TRIG_RISE:   f = v.cur & ~v.prev;
            TRIG_FALL:   f = ~v.cur & v.prev;
            default:     f = v.cur ^ v.prev;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_req_t           req,
    input  logic [NPINS-1:0]   pin_level,
    input  logic [NPINS-1:0]   status,
    output logic [NPINS-1:0]   latch_q,
    output logic [NPINS-1:0]   mask_q,
    output logic [2*NPINS-1:0] edge_q,
    output logic [NPINS-1:0]   clr_pulse,
    output logic [NPINS-1:0]   ref_q,
    output logic [7:0]         rdata
);
    // NPINS must be a multiple of 8 and at most 32 for this address map
    localparam int NBYTES  = NPINS / 8;
    localparam int NEBYTES = NPINS / 4;

    logic [7:0] latch_b [NBYTES];
    logic [7:0] mask_b  [NBYTES];
    logic [7:0] ref_b   [NBYTES];
    logic [7:0] edge_b  [NEBYTES];
    logic [7:0] rd_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_b <= '{default: 8'h00};
            mask_b  <= '{default: 8'hFF};
            ref_b   <= '{default: 8'h00};
            edge_b  <= '{default: 8'h00};
        end else begin
            for (int b = 0; b < NBYTES; b++) begin
                if (req.wr && req.addr == A_LATCH + 8'(b)) latch_b[b] <= req.data;
                if (req.wr && req.addr == A_MASK + 8'(b))  mask_b[b]  <= req.data;
                if (req.rd && req.addr == A_LEVEL + 8'(b)) ref_b[b]   <= pin_level[b*8 +: 8];
            end
            for (int e = 0; e < NEBYTES; e++) begin
                if (req.wr && req.addr == A_EDGE + 8'(e)) edge_b[e] <= req.data;
            end
        end
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign latch_q[b*8 +: 8]   = latch_b[b];
        assign mask_q[b*8 +: 8]    = mask_b[b];
        assign ref_q[b*8 +: 8]     = ref_b[b];
        assign clr_pulse[b*8 +: 8] = (req.wr && req.addr == A_CLEAR + 8'(b)) ? req.data : 8'h00;
    end

    for (genvar e = 0; e < NEBYTES; e++) begin : g_edge
        assign edge_q[e*8 +: 8] = edge_b[e];
    end

    always_comb begin
        rd_val = 8'h00;
        for (int b = 0; b < NBYTES; b++) begin
            if (req.addr == A_LATCH + 8'(b)) rd_val = latch_b[b];
            if (req.addr == A_MASK + 8'(b))  rd_val = mask_b[b];
            if (req.addr == A_STAT + 8'(b))  rd_val = status[b*8 +: 8];
            if (req.addr == A_LEVEL + 8'(b)) rd_val = pin_level[b*8 +: 8];
        end
        for (int e = 0; e < NEBYTES; e++) begin
            if (req.addr == A_EDGE + 8'(e)) rd_val = edge_b[e];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= 8'h00;
        else if (req.rd) rdata <= rd_val;
    end

endmodule

// File: rtl/pin_irq_cell.sv
module pin_irq_cell
    import pin_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_mode_e mode,
    input  logic       cur,
    input  logic       prev,
    input  logic       ref_lvl,
    input  logic       armed,
    input  logic       latch_en,
    input  logic       clr,
    output logic       pend
);
    logic      evt_lvl;
    logic      hit;
    pin_view_t view;

    assign view = '{cur: cur, prev: prev, ref_lvl: ref_lvl};
    assign hit  = armed & fires(mode, view);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            evt_lvl <= 1'b0;
        end else if (hit) begin
            pend    <= 1'b1;
            evt_lvl <= cur;
        end else if (clr) begin
            pend    <= 1'b0;
        end else if (pend && !latch_en && (cur != evt_lvl)) begin
            pend    <= 1'b0;
        end
    end

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
    import pin_irq_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       addr,
    input  logic [7:0]       wdata,
    input  logic [NPINS-1:0] pin_level,
    input  logic [NPINS-1:0] pin_is_input,
    output logic [7:0]       rdata,
    output logic             irq_n
);
    bus_req_t           req;
    logic [NPINS-1:0]   latch_q;
    logic [NPINS-1:0]   mask_q;
    logic [NPINS-1:0]   clr_pulse;
    logic [NPINS-1:0]   ref_q;
    logic [NPINS-1:0]   pend;
    logic [NPINS-1:0]   status;
    logic [NPINS-1:0]   lvl_prev;
    logic [2*NPINS-1:0] edge_q;

    assign req = '{wr: wr_en, rd: rd_en, addr: addr, data: wdata};

    always_ff @(posedge clk) begin
        if (rst) lvl_prev <= '0;
        else     lvl_prev <= pin_level;
    end

    pin_irq_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .pin_level (pin_level),
        .status    (status),
        .latch_q   (latch_q),
        .mask_q    (mask_q),
        .edge_q    (edge_q),
        .clr_pulse (clr_pulse),
        .ref_q     (ref_q),
        .rdata     (rdata)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_irq_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .mode     (trig_mode_e'(edge_q[2*i +: 2])),
            .cur      (pin_level[i]),
            .prev     (lvl_prev[i]),
            .ref_lvl  (ref_q[i]),
            .armed    (pin_is_input[i] & ~mask_q[i]),
            .latch_en (latch_q[i]),
            .clr      (clr_pulse[i]),
            .pend     (pend[i])
        );
    end

    assign status = pend & ~mask_q & pin_is_input;
    assign irq_n  = ~|status;

endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk #(
    parameter int NPINS = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_n,
    input logic [NPINS-1:0] pin_is_input,
    input logic [NPINS-1:0] pend,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] latch_q,
    input logic [NPINS-1:0] clr_pulse
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> irq_n);

    // R2
    output_pin_silent_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(~pin_is_input & ~pend)) == '0));

    // R3
    masked_pin_silent_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(mask_q & ~pend)) == '0));

    // R9
    latched_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~pend & $past(pend & latch_q & ~clr_pulse)) == '0));

    // R11
    irq_steady_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(pend) && $stable(mask_q) && $stable(pin_is_input)) |-> $stable(irq_n));

endmodule

bind pin_irq_ctrl pin_irq_chk #(.NPINS(NPINS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .irq_n        (irq_n),
    .pin_is_input (pin_is_input),
    .pend         (pend),
    .mask_q       (mask_q),
    .latch_q      (latch_q),
    .clr_pulse    (clr_pulse)
);

// File: tb/pin_irq_ctrl_tb.sv
module pin_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    addr = 8'h00;
    logic [7:0]    wdata = 8'h00;
    logic [NP-1:0] lvl = '0;
    logic [NP-1:0] dir = '1;
    logic [7:0]    rdata;
    logic          irq_n;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // bench model state
    logic [NP-1:0]   m_pend, m_evt, m_prev, m_ref, m_mask, m_latch;
    logic [2*NP-1:0] m_edge;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_irq_ctrl #(.NPINS(NP)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .pin_level(lvl), .pin_is_input(dir),
        .rdata(rdata), .irq_n(irq_n)
    );

    always @(posedge clk) begin
        logic [NP-1:0] np;
        logic [NP-1:0] ne;
        if (rst) begin
            m_pend <= '0; m_evt <= '0; m_prev <= '0; m_ref <= '0;
            m_mask <= '1; m_latch <= '0; m_edge <= '0;
        end else begin
            np = m_pend;
            ne = m_evt;
            for (int i = 0; i < NP; i++) begin
                logic hit;
                logic clr;
                case (m_edge[2*i +: 2])
                    2'b00:   hit = lvl[i] ^ m_ref[i];
                    2'b01:   hit = lvl[i] & ~m_prev[i];
                    2'b10:   hit = ~lvl[i] & m_prev[i];
                    default: hit = lvl[i] ^ m_prev[i];
                endcase
                hit = hit & dir[i] & ~m_mask[i];
                clr = wr_en && (addr == 8'h10 + 8'(i/8)) && wdata[i%8];
                if (hit) begin np[i] = 1'b1; ne[i] = lvl[i]; end
                else if (clr) np[i] = 1'b0;
                else if (m_pend[i] && !m_latch[i] && lvl[i] != m_evt[i]) np[i] = 1'b0;
            end
            m_pend <= np;
            m_evt  <= ne;
            m_prev <= lvl;
            for (int b = 0; b < NP/8; b++) begin
                if (wr_en && addr == 8'h00 + 8'(b)) m_latch[b*8 +: 8] <= wdata;
                if (wr_en && addr == 8'h04 + 8'(b)) m_mask[b*8 +: 8]  <= wdata;
                if (rd_en && addr == 8'h18 + 8'(b)) m_ref[b*8 +: 8]   <= lvl[b*8 +: 8];
            end
            for (int e = 0; e < NP/4; e++)
                if (wr_en && addr == 8'h08 + 8'(e)) m_edge[e*8 +: 8] <= wdata;
        end
    end

    function automatic logic model_irq_n();
        return ~|(m_pend & ~m_mask & dir);
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] a);
        logic [7:0] v = 8'h00;
        for (int b = 0; b < NP/8; b++) begin
            if (a == 8'h00 + 8'(b)) v = m_latch[b*8 +: 8];
            if (a == 8'h04 + 8'(b)) v = m_mask[b*8 +: 8];
            if (a == 8'h14 + 8'(b)) v = (m_pend & ~m_mask & dir) >> (b*8);
            if (a == 8'h18 + 8'(b)) v = lvl[b*8 +: 8];
        end
        for (int e = 0; e < NP/4; e++)
            if (a == 8'h08 + 8'(e)) v = m_edge[e*8 +: 8];
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        step();
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        bus_rd(a, d);
        check(tag, {24'h0, d}, {24'h0, exp});
    endtask

    task automatic pin0(input logic v);
        lvl[0] = v;
        step();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got %0d cycles expected completion", cycles);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();

        // R1 reset state
        check("R1 irq_n after reset", {31'h0, irq_n}, 32'h1);
        rd_chk("R1 mask byte0", 8'h04, 8'hFF);
        rd_chk("R1 status byte0", 8'h14, 8'h00);

        // R12 readback
        bus_wr(8'h04, 8'hFE);
        bus_wr(8'h08, 8'h01);
        rd_chk("R12 edge byte0", 8'h08, 8'h01);
        bus_wr(8'h01, 8'h5A);
        rd_chk("R12 latch byte1", 8'h01, 8'h5A);
        bus_wr(8'h01, 8'h00);

        // R4 rising only, R8 unlatched revert
        pin0(1'b1); check("R4 rise fires", {31'h0, irq_n}, 32'h0);
        pin0(1'b0); check("R8 revert drops", {31'h0, irq_n}, 32'h1);

        // R5 falling only
        bus_wr(8'h08, 8'h02);
        pin0(1'b1); check("R5 rise ignored", {31'h0, irq_n}, 32'h1);
        pin0(1'b0); check("R5 fall fires", {31'h0, irq_n}, 32'h0);
        rd_chk("R11 status pin0", 8'h14, 8'h01);
        bus_wr(8'h10, 8'h01);
        check("R10 clear", {31'h0, irq_n}, 32'h1);
        rd_chk("R10 clear reads zero", 8'h10, 8'h00);

        // R6 both edges
        bus_wr(8'h08, 8'h03);
        pin0(1'b1); check("R6 rise fires", {31'h0, irq_n}, 32'h0);
        bus_wr(8'h10, 8'h01);
        pin0(1'b0); check("R6 fall fires", {31'h0, irq_n}, 32'h0);
        bus_wr(8'h10, 8'h01);

        // R9 latched hold
        bus_wr(8'h00, 8'h01);
        bus_wr(8'h08, 8'h01);
        pin0(1'b1);
        pin0(1'b0); check("R9 latched survives revert", {31'h0, irq_n}, 32'h0);
        bus_wr(8'h10, 8'h01);
        check("R9 clear releases", {31'h0, irq_n}, 32'h1);
        bus_wr(8'h00, 8'h00);

        // R10 clear coinciding with new event
        lvl[0] = 1'b1;
        bus_wr(8'h10, 8'h01);
        check("R10 event beats clear", {31'h0, irq_n}, 32'h0);
        pin0(1'b0);

        // R7 change against reference
        bus_wr(8'h08, 8'h00);
        pin0(1'b1); check("R7 differs from ref", {31'h0, irq_n}, 32'h0);
        pin0(1'b0); check("R7 back to ref", {31'h0, irq_n}, 32'h1);
        pin0(1'b1);
        rd_chk("R7 level read", 8'h18, 8'h01);
        bus_wr(8'h10, 8'h01);
        check("R7 equal to new ref", {31'h0, irq_n}, 32'h1);
        pin0(1'b0); check("R7 differs from new ref", {31'h0, irq_n}, 32'h0);
        bus_wr(8'h08, 8'h01);
        pin0(1'b1);
        pin0(1'b0);
        bus_wr(8'h10, 8'h01);

        // R3 masked pin
        bus_wr(8'h04, 8'hFF);
        bus_wr(8'h08, 8'h03);
        pin0(1'b1); check("R3 masked no irq", {31'h0, irq_n}, 32'h1);
        rd_chk("R3 masked status", 8'h14, 8'h00);
        pin0(1'b0);

        // R2 output pin
        bus_wr(8'h04, 8'hFE);
        dir[0] = 1'b0;
        pin0(1'b1); check("R2 output no irq", {31'h0, irq_n}, 32'h1);
        pin0(1'b0);
        rd_chk("R2 output status", 8'h14, 8'h00);
        dir[0] = 1'b1;
        step();

        // R11 bit position, pin 13
        bus_wr(8'h05, 8'hDF);
        bus_wr(8'h0B, 8'h04);
        lvl[13] = 1'b1;
        step();
        check("R11 pin13 irq", {31'h0, irq_n}, 32'h0);
        rd_chk("R11 status byte1", 8'h15, 8'h20);
        rd_chk("R11 status byte0", 8'h14, 8'h00);
        bus_wr(8'h11, 8'h20);
        check("R10 clear byte1", {31'h0, irq_n}, 32'h1);
        lvl[13] = 1'b0;
        step();

        // random phase against model
        for (int it = 0; it < 3000; it++) begin
            logic [7:0] a;
            logic [7:0] exp_rd;
            int op;
            bit do_rd;
            do_rd = 1'b0;
            if ($urandom % 3 == 0) lvl[$urandom % NP] ^= 1'b1;
            if ($urandom % 40 == 0) dir[$urandom % NP] ^= 1'b1;
            op = int'($urandom % 12);
            case (op)
                0: begin wr_en = 1'b1; addr = 8'(($urandom % 3));          wdata = 8'($urandom); end
                1: begin wr_en = 1'b1; addr = 8'h04 + 8'(($urandom % 3));  wdata = 8'($urandom) & 8'($urandom); end
                2: begin wr_en = 1'b1; addr = 8'h08 + 8'(($urandom % 6));  wdata = 8'($urandom); end
                3: begin wr_en = 1'b1; addr = 8'h10 + 8'(($urandom % 3));  wdata = 8'($urandom); end
                4: begin do_rd = 1'b1; a = 8'h14 + 8'(($urandom % 3)); end
                5: begin do_rd = 1'b1; a = 8'h18 + 8'(($urandom % 3)); end
                6: begin do_rd = 1'b1; a = 8'h08 + 8'(($urandom % 6)); end
                default: ;
            endcase
            if (do_rd) begin
                rd_en = 1'b1; addr = a;
                exp_rd = model_read(a);
            end
            step();
            wr_en = 1'b0;
            rd_en = 1'b0;
            check("R11 random irq_n", {31'h0, irq_n}, {31'h0, model_irq_n()});
            if (do_rd) check("R12 random readback", {24'h0, rdata}, {24'h0, exp_rd});
        end

        finish_run();
    end
endmodule